// File: doc/BRIEF.md
# Keyed-Reload Watchdog Timer

This block is a watchdog down-counter whose 24-bit reload value sits in three byte registers: upper, high and low. A small write bus (address, data, strobe) reaches those registers, but only through a lock. Software must first write a two-byte key to the control address. It must then write the three reload bytes in a fixed order, with no other write in between. Any stray write closes the lock again, and so does finishing the sequence. The same control address also holds one mode bit, which selects whether a time-out asks for a reset or raises an interrupt.

While enabled, the counter steps down once per cycle in which `tick` is high. It reloads when it is first enabled, on every `refresh` strobe, and on every time-out. In reset mode, a time-out asks for a system reset in normal operation and for a stop-mode recovery when `stop_mode` is high. Each of these requests sets sticky status flags. In interrupt mode, a time-out raises a one-cycle interrupt and leaves the flags alone. The flags are cleared only by `stat_clr` or by `rst_n`, so a reset caused by the watchdog itself does not erase the evidence of what caused it.

Top module: `wdt_keyed_guard`

## Requirements
- R1: After `rst_n` is asserted, every request output and both flags are 0, the mode bit is 0 (reset mode), the lock is closed, and the reload value equals the `RESET_RELOAD` parameter.
- R2: The address map is as follows. Address 0 is control, and its bit 0 set to 1 selects interrupt mode. Address 1 holds reload bits [23:16], address 2 holds bits [15:8] and address 3 holds bits [7:0]. Writing 0x55 and then 0xAA to address 0 on two consecutive writes opens the lock.
- R3: A control write whose data is 0x55 or 0xAA never changes the mode bit. Any other control write loads bit 0 of the data into the mode bit.
- R4: Once the lock is open, the reload bytes are accepted only in the order address 1, then 2, then 3. Each byte is stored as it is written. Writing address 3 closes the lock again.
- R5: Any write that breaks the sequence closes the lock and stores nothing. This includes a wrong address or wrong data between or after the keys, and a control write during the byte phase. Opening the lock again requires a new 0x55.
- R6: A write to a reload address while the lock is closed leaves the stored value unchanged.
- R7: The counter loads the reload value in the cycle `enable` rises and in any enabled cycle with `refresh` high. A load takes precedence over a tick in the same cycle.
- R8: Each enabled cycle with `tick` high and no load decrements the counter. With reload N ≥ 1, the time-out occurs on the N-th tick after a load. The counter reloads on time-out and continues. Request outputs are high for exactly the one cycle after the edge that sampled that tick.
- R9: In reset mode with `stop_mode` low, a time-out pulses `sys_rst_req` and sets `flag_wdt`.
- R10: In reset mode with `stop_mode` high, a time-out pulses `stop_rec_req` instead of `sys_rst_req` and sets both `flag_wdt` and `flag_stop`.
- R11: In interrupt mode, a time-out pulses `irq_req` only, leaves both flags unchanged, and the countdown keeps repeating.
- R12: The flags stay set until a cycle with `stat_clr` high, or until `rst_n` is asserted.
- R13: While `enable` is low, the counter holds and no time-out occurs, whatever `tick` and `refresh` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| refresh | input | 1 | Reload strobe from software |
| enable | input | 1 | Watchdog enable |
| tick | input | 1 | One watchdog clock tick in this cycle |
| stop_mode | input | 1 | Device is in stop mode |
| stat_clr | input | 1 | Clears both status flags |
| sys_rst_req | output | 1 | One-cycle system reset request |
| stop_rec_req | output | 1 | One-cycle stop-mode recovery request |
| irq_req | output | 1 | One-cycle interrupt request |
| flag_wdt | output | 1 | Sticky watchdog time-out flag |
| flag_stop | output | 1 | Sticky time-out-in-stop-mode flag |

## Verification
The hardest states to reach from the ports are the partly opened lock states: after the first key only, and after one or two reload bytes. From those states, the only visible effect of a stray write is that a later reload byte is silently dropped. The stimulus drives aborted sequences (a stray write between the keys, a byte out of order, and a control write in the middle of the byte phase) and then tries to finish each one. The result shows in the position of the next time-out, which the scoreboard predicts to the cycle. A locked write, and a write made just after the sequence has closed the lock, are judged the same way.

// File: rtl/wdtg_pkg.sv
package wdtg_pkg;
  localparam int BYTE_W   = 8;
  localparam int NBYTES   = 3;
  localparam int RELOAD_W = BYTE_W * NBYTES;
  localparam int ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_UPPER = 2'd1;
  localparam logic [ADDR_W-1:0] A_HIGH  = 2'd2;
  localparam logic [ADDR_W-1:0] A_LOW   = 2'd3;

  localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;

  // Lock progress: closed, first key seen, then waiting for each reload byte in turn
  typedef enum logic [2:0] {
    LK_SHUT   = 3'd0,
    LK_HALF   = 3'd1,
    LK_WANT_U = 3'd2,
    LK_WANT_H = 3'd3,
    LK_WANT_L = 3'd4
  } lock_e;
endpackage

// File: rtl/wdtg_unlock.sv
module wdtg_unlock
  import wdtg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [BYTE_W-1:0]        wr_data,
  output logic [NBYTES-1:0]        byte_we,
  output logic                     irq_mode,
  output lock_e                    lk_state
);
  lock_e st_q, st_d;
  logic  mode_q, mode_d, mode_en;
  logic  is_ctrl, is_key;

  assign is_ctrl = (wr_addr == A_CTRL);
  assign is_key  = (wr_data == KEY_FIRST) || (wr_data == KEY_SECOND);

  // Next state and byte strobes (index 2 = upper, 1 = high, 0 = low)
  always_comb begin
    st_d    = st_q;
    byte_we = '0;
    if (wr_en) begin
      unique case (st_q)
        LK_SHUT:   st_d = (is_ctrl && wr_data == KEY_FIRST)  ? LK_HALF   : LK_SHUT;
        LK_HALF:   st_d = (is_ctrl && wr_data == KEY_SECOND) ? LK_WANT_U : LK_SHUT;
        LK_WANT_U: begin
          if (wr_addr == A_UPPER) begin
            byte_we[2] = 1'b1;
            st_d       = LK_WANT_H;
          end else begin
            st_d       = LK_SHUT;
          end
        end
        LK_WANT_H: begin
          if (wr_addr == A_HIGH) begin
            byte_we[1] = 1'b1;
            st_d       = LK_WANT_L;
          end else begin
            st_d       = LK_SHUT;
          end
        end
        LK_WANT_L: begin
          if (wr_addr == A_LOW) begin
            byte_we[0] = 1'b1;
          end
          st_d = LK_SHUT;
        end
        default:   st_d = LK_SHUT;
      endcase
    end
  end

  // Mode bit: key values never reach it
  always_comb begin
    mode_en = wr_en && is_ctrl && !is_key;
    mode_d  = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_SHUT;
      mode_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (mode_en) begin
        mode_q <= mode_d;
      end
    end
  end

  assign irq_mode = mode_q;
  assign lk_state = st_q;

  assert_key_keeps_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_ctrl && is_key) |=> $stable(mode_q));

  assert_relock_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && st_q == LK_WANT_L) |=> (st_q == LK_SHUT));

  assert_stray_write_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && st_q == LK_WANT_U && wr_addr != A_UPPER) |=> (st_q == LK_SHUT));
endmodule

// File: rtl/wdtg_reload.sv
module wdtg_reload
  import wdtg_pkg::*;
#(
  parameter logic [RELOAD_W-1:0] RESET_RELOAD = 24'h00_1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NBYTES-1:0]   byte_we,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [RELOAD_W-1:0] reload
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_q <= RESET_RELOAD[i*BYTE_W +: BYTE_W];
      end else if (byte_we[i]) begin
        b_q <= wr_data;
      end
    end
    assign reload[i*BYTE_W +: BYTE_W] = b_q;

    assert_byte_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
      byte_we[i] |=> (b_q == $past(wr_data)));
  end

  assert_single_byte_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(byte_we));
endmodule

// File: rtl/wdtg_counter.sv
module wdtg_counter
  import wdtg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                refresh,
  input  logic                tick,
  input  logic [RELOAD_W-1:0] reload,
  output logic                expire
);
  logic [RELOAD_W-1:0] cnt_q, cnt_d;
  logic                en_q;
  logic                load, step, last;

  assign load   = (enable && !en_q) || (enable && refresh);
  assign step   = enable && tick && !load;
  assign last   = (cnt_q[RELOAD_W-1:1] == '0);
  assign expire = step && last;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = reload;
    end else if (step) begin
      cnt_d = last ? reload : cnt_q - RELOAD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= enable;
      if (load || step) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assert_load_takes_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(reload)));

  assert_step_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && !load && cnt_q > RELOAD_W'(1)) |=> (cnt_q == $past(cnt_q) - RELOAD_W'(1)));

  assert_hold_disabled_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(cnt_q));

  assert_no_expire_disabled_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !expire);
endmodule

// File: rtl/wdtg_status.sv
module wdtg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic irq_mode,
  input  logic stop_mode,
  input  logic stat_clr,
  output logic sys_rst_req,
  output logic stop_rec_req,
  output logic irq_req,
  output logic flag_wdt,
  output logic flag_stop
);
  logic rst_d, rec_d, irq_d;
  logic rst_q, rec_q, irq_q;
  logic fw_q, fw_d, fs_q, fs_d;
  logic hit_reset;

  assign hit_reset = expire && !irq_mode;

  always_comb begin
    rst_d = hit_reset && !stop_mode;
    rec_d = hit_reset && stop_mode;
    irq_d = expire && irq_mode;
    fw_d  = fw_q;
    fs_d  = fs_q;
    if (stat_clr) begin
      fw_d = 1'b0;
      fs_d = 1'b0;
    end
    if (hit_reset) begin
      fw_d = 1'b1;
      if (stop_mode) begin
        fs_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      rec_q <= 1'b0;
      irq_q <= 1'b0;
      fw_q  <= 1'b0;
      fs_q  <= 1'b0;
    end else begin
      rst_q <= rst_d;
      rec_q <= rec_d;
      irq_q <= irq_d;
      fw_q  <= fw_d;
      fs_q  <= fs_d;
    end
  end

  assign sys_rst_req  = rst_q;
  assign stop_rec_req = rec_q;
  assign irq_req      = irq_q;
  assign flag_wdt     = fw_q;
  assign flag_stop    = fs_q;

  assert_one_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_q, rec_q, irq_q}));

  assert_stop_needs_wdt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> fw_q);

  assert_irq_keeps_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && irq_mode && !stat_clr) |=> ($stable(fw_q) && $stable(fs_q)));

  assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_q && !stat_clr) |=> fw_q);
endmodule

// File: rtl/wdt_keyed_guard.sv
module wdt_keyed_guard
  import wdtg_pkg::*;
#(
  parameter logic [RELOAD_W-1:0] RESET_RELOAD = 24'h00_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              refresh,
  input  logic              enable,
  input  logic              tick,
  input  logic              stop_mode,
  input  logic              stat_clr,
  output logic              sys_rst_req,
  output logic              stop_rec_req,
  output logic              irq_req,
  output logic              flag_wdt,
  output logic              flag_stop
);
  // Reset: asserted at once, released on a clock edge
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic [NBYTES-1:0]   byte_we;
  logic [RELOAD_W-1:0] reload;
  logic                irq_mode;
  logic                expire;
  lock_e               lk_state;

  wdtg_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rs_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .byte_we  (byte_we),
    .irq_mode (irq_mode),
    .lk_state (lk_state)
  );

  wdtg_reload #(.RESET_RELOAD(RESET_RELOAD)) u_reload (
    .clk     (clk),
    .rst_n   (rs_n),
    .byte_we (byte_we),
    .wr_data (wr_data),
    .reload  (reload)
  );

  wdtg_counter u_counter (
    .clk     (clk),
    .rst_n   (rs_n),
    .enable  (enable),
    .refresh (refresh),
    .tick    (tick),
    .reload  (reload),
    .expire  (expire)
  );

  wdtg_status u_status (
    .clk          (clk),
    .rst_n        (rs_n),
    .expire       (expire),
    .irq_mode     (irq_mode),
    .stop_mode    (stop_mode),
    .stat_clr     (stat_clr),
    .sys_rst_req  (sys_rst_req),
    .stop_rec_req (stop_rec_req),
    .irq_req      (irq_req),
    .flag_wdt     (flag_wdt),
    .flag_stop    (flag_stop)
  );

  assert_locked_write_ignored_R6: assert property (@(posedge clk) disable iff (!rs_n)
    (wr_en && (lk_state == LK_SHUT || lk_state == LK_HALF)) |=> $stable(reload));
endmodule

// File: tb/sim_wdt_keyed_guard.sv
module sim_wdt_keyed_guard;
  localparam int RST_RL = 300;
  localparam logic [1:0] K_RST = 2'd0, K_REC = 2'd1, K_IRQ = 2'd2;

  typedef struct { logic [1:0] kind; int at; string req; } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       refresh = 1'b0, enable = 1'b0, tick = 1'b0, stop_mode = 1'b0, stat_clr = 1'b0;
  logic       sys_rst_req, stop_rec_req, irq_req, flag_wdt, flag_stop;

  int   cyc = 0;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_keyed_guard #(.RESET_RELOAD(24'(RST_RL))) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .refresh(refresh), .enable(enable), .tick(tick), .stop_mode(stop_mode),
    .stat_clr(stat_clr), .sys_rst_req(sys_rst_req), .stop_rec_req(stop_rec_req),
    .irq_req(irq_req), .flag_wdt(flag_wdt), .flag_stop(flag_stop)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: every request pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic int cnt = int'(sys_rst_req) + int'(stop_rec_req) + int'(irq_req);
      automatic logic [1:0] k = sys_rst_req ? K_RST : (stop_rec_req ? K_REC : K_IRQ);
      if (cnt > 1) check("R9 one request at a time", cnt, 1);
      else if (cnt == 1) begin
        if (sb.size() == 0) check("R13 unexpected time-out", 1, 0);
        else begin
          automatic exp_t e = sb.pop_front();
          check({e.req, " kind"}, int'(k), int'(e.kind));
          check({e.req, " cycle"}, cyc, e.at);
        end
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic open_load(int v);
    wr(2'd0, 8'h55); wr(2'd0, 8'hAA);
    wr(2'd1, v[23:16]); wr(2'd2, v[15:8]); wr(2'd3, v[7:0]);
  endtask

  // Driver: refresh now, predict the time-out(s), wait for the monitor to consume them
  task automatic kick(int n, logic [1:0] kind, int reps, string req);
    refresh = 1'b1; tick = 1'b1;
    for (int r = 1; r <= reps; r++) sb.push_back('{kind, cyc + 1 + r * n, req});
    @(negedge clk);
    refresh = 1'b0;
    for (int w = 0; w < 4 * n * reps + 20 && sb.size() != 0; w++) @(negedge clk);
    if (sb.size() != 0) begin
      check({req, " time-out missing"}, sb.size(), 0);
      sb.delete();
    end
    tick = 1'b0;
  endtask

  task automatic clear_flags();
    stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    check("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: quiet after reset
    check("R1 sys_rst_req", sys_rst_req, 0);
    check("R1 stop_rec_req", stop_rec_req, 0);
    check("R1 irq_req", irq_req, 0);
    check("R1 flag_wdt", flag_wdt, 0);
    check("R1 flag_stop", flag_stop, 0);
    enable = 1'b1; @(negedge clk);
    // R1/R8/R9: default reload, reset mode
    kick(RST_RL, K_RST, 1, "R1 default reload");
    check("R9 flag_wdt", flag_wdt, 1);
    check("R9 flag_stop", flag_stop, 0);
    repeat (20) @(negedge clk);
    check("R12 flag held", flag_wdt, 1);
    clear_flags();
    check("R12 flag cleared", flag_wdt, 0);
    // R2/R4: full sequence loads 5
    open_load(5);
    kick(5, K_RST, 1, "R2 unlock and load");
    clear_flags();
    // R10: stop mode
    stop_mode = 1'b1;
    kick(5, K_REC, 1, "R10 stop recovery");
    check("R10 flag_wdt", flag_wdt, 1);
    check("R10 flag_stop", flag_stop, 1);
    stop_mode = 1'b0;
    clear_flags();
    check("R12 stop flag cleared", flag_stop, 0);
    // R6: locked write dropped
    wr(2'd3, 8'd2);
    kick(5, K_RST, 1, "R6 locked write ignored");
    // R5: out-of-order byte
    wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd2, 8'd0); wr(2'd3, 8'd2);
    kick(5, K_RST, 1, "R5 wrong order");
    // R5: stray write between keys
    wr(2'd0, 8'h55); wr(2'd1, 8'd0); wr(2'd0, 8'hAA);
    wr(2'd1, 8'd0); wr(2'd2, 8'd0); wr(2'd3, 8'd2);
    kick(5, K_RST, 1, "R5 break between keys");
    // R5: control write in byte phase
    wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd1, 8'd0); wr(2'd2, 8'd0);
    wr(2'd0, 8'h00); wr(2'd3, 8'd2);
    kick(5, K_RST, 1, "R5 break in byte phase");
    // R4: relock after low byte
    open_load(7);
    wr(2'd3, 8'd3);
    kick(7, K_RST, 1, "R4 relock after sequence");
    // R2: high byte position
    open_load(259);
    kick(259, K_RST, 1, "R2 high byte position");
    open_load(5);
    clear_flags();
    // R11: interrupt mode repeats, flags untouched
    wr(2'd0, 8'h01);
    kick(5, K_IRQ, 2, "R11 interrupt repeats");
    check("R11 flag_wdt", flag_wdt, 0);
    // R3: key value leaves mode
    wr(2'd0, 8'hAA);
    kick(5, K_IRQ, 1, "R3 key keeps mode");
    wr(2'd0, 8'h55); wr(2'd0, 8'h02);
    kick(5, K_RST, 1, "R3 plain write sets mode");
    // R7: refresh postpones the time-out
    refresh = 1'b1; tick = 1'b1; @(negedge clk); refresh = 1'b0;
    repeat (3) @(negedge clk);
    kick(5, K_RST, 1, "R7 refresh postpones");
    // R13: disabled, nothing happens
    enable = 1'b0; tick = 1'b1; refresh = 1'b1;
    repeat (30) @(negedge clk);
    refresh = 1'b0;
    check("R13 no request while disabled", sys_rst_req, 0);
    // R7: enable rising loads
    enable = 1'b1;
    sb.push_back('{K_RST, cyc + 1 + 5, "R7 enable load"});
    for (int w = 0; w < 40 && sb.size() != 0; w++) @(negedge clk);
    check("R7 enable load seen", sb.size(), 0);
    sb.delete();
    tick = 1'b0;
    check("R12 flag before reset", flag_wdt, 1);
    // R1/R12: power-on reset clears flags
    rst_n = 1'b0; @(negedge clk);
    check("R12 reset clears flag_wdt", flag_wdt, 0);
    check("R1 reset clears flag_stop", flag_stop, 0);
    finish_run();
  end
endmodule